// File: doc/BRIEF.md
# Vector Lane Predicate Mask Generator

This block produces the 16-bit byte-lane enable mask that a vector load, store or arithmetic unit uses to decide which lanes it may write. It merges three independent sources of masking in a fixed order. First comes the lane predicate with its two 4-bit phase fields, which gate the low and high halves. Next comes final-iteration tail masking, driven by a loop element count and an element-size code. Last comes partial-beat resumption, driven by an interrupted-instruction beat code carried in an execution-state byte.

Each mask bit stands for one byte lane. The block also derives a per-element enable vector for the operand width of the current instruction. A byte operation takes every mask bit. A halfword operation takes every second bit, starting at bit 0. A word operation takes every fourth bit, starting at bit 0. The unit is combinational at heart. An elaboration option registers both outputs, which gives exactly one cycle of latency. All pins are plain control and status pins with no handshake, because each result is a pure function of the inputs in the same cycle.

Top module: `lane_pred_mask_gen`

## Requirements
- R1: The mask starts as `pred_bits`. When `phase_lo` is 0, bits 7:0 are forced to 1. When `phase_hi` is 0, bits 15:8 are forced to 1. Otherwise that half keeps the predicate bits.
- R2: When `tail_size` < 4 and `loop_cnt` <= 16 >> `tail_size`, only the low (`loop_cnt` << `tail_size`) mask bits are kept and all higher bits are cleared. For example, a count of 0 clears every bit, and a count of 16 with size 0 clears none.
- R3: No tail clearing happens when `tail_size` >= 4, or when `loop_cnt` is above the window, at any count width. Any kept length above 16 keeps all 16 bits.
- R4: The beat code is `exec_state[7:4]`. It is applied only when `exec_state[3:0]` is 0. Otherwise the beat stage passes the mask through.
- R5: The beat codes clear lanes as follows. Code 0 clears nothing. Code 1 clears bits 3:0. Code 2 clears bits 7:0. Codes 4 and 5 clear bits 11:0.
- R6: The reserved beat codes (3 and 6 to 15) leave the mask unchanged.
- R7: `elem_en[e]` follows `op_width`. Code 0 (byte) gives mask[e] for e 0..15. Code 1 (halfword) gives mask[2e] for e 0..7. Code 2 (word) gives mask[4e] for e 0..3. Element bits beyond the element count are 0, and code 3 gives all zeros.
- R8: With `REG_OUT`=1, both outputs are registered. They change one clock after the inputs and are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered-output option |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_bits | input | 16 | Per-byte-lane predicate |
| phase_lo | input | 4 | Mask-phase field for lanes 7:0 |
| phase_hi | input | 4 | Mask-phase field for lanes 15:8 |
| loop_cnt | input | CNT_W | Remaining loop element count |
| tail_size | input | 3 | Element-size code for tail masking (4 or more disables it) |
| exec_state | input | 8 | Execution state: beat code in 7:4, guard in 3:0 |
| op_width | input | 2 | Operand width: 0 byte, 1 halfword, 2 word, 3 none |
| lane_mask | output | 16 | Combined byte-lane enable mask |
| elem_en | output | 16 | Per-element enables for `op_width` |

## Verification
The assertions assume that every input holds steady from one rising edge to the next. They also assume that, with the registered option, each output relates to the inputs sampled at the edge before it. The bench meets this by changing inputs only on the falling edge and reading outputs on the following falling edge. The assertions do not assume any legal encoding of the beat code or the size code. Because of that, the stimulus deliberately includes reserved beat codes, sizes of 4 or more, and counts far above the tail window.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LANES    = 16;
  localparam int HALF     = LANES / 2;
  localparam int QUART    = LANES / 4;
  localparam int BEAT_W   = LANES / 4;
  typedef logic [LANES-1:0] lane_vec_t;

  typedef enum logic [1:0] {
    OPW_BYTE = 2'd0,
    OPW_HALF = 2'd1,
    OPW_WORD = 2'd2,
    OPW_NONE = 2'd3
  } opw_e;

  localparam logic [3:0] BEAT_NONE = 4'd0;
  localparam logic [3:0] BEAT_ONE  = 4'd1;
  localparam logic [3:0] BEAT_TWO  = 4'd2;
  localparam logic [3:0] BEAT_THR  = 4'd4;
  localparam logic [3:0] BEAT_THRX = 4'd5;

  localparam logic [2:0] TAIL_OFF_MIN = 3'd4;
endpackage

// File: rtl/lpm_pred_stage.sv
module lpm_pred_stage
  import lpm_pkg::*;
(
  input  lane_vec_t  pred_bits,
  input  logic [3:0] phase_lo,
  input  logic [3:0] phase_hi,
  output lane_vec_t  base_mask
);
  logic [1:0] half_open;
  assign half_open = {(phase_hi == 4'd0), (phase_lo == 4'd0)};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign base_mask[h*HALF +: HALF] =
      half_open[h] ? {HALF{1'b1}} : pred_bits[h*HALF +: HALF];
  end
endmodule

// File: rtl/lpm_tail_stage.sv
module lpm_tail_stage
  import lpm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  lane_vec_t        in_mask,
  input  logic [CNT_W-1:0] loop_cnt,
  input  logic [2:0]       tail_size,
  output lane_vec_t        out_mask
);
  localparam int LEN_W = $clog2(LANES) + 3;

  logic [CNT_W-1:0] limit;
  logic             active;
  logic [LEN_W-1:0] raw_len;
  logic [LEN_W-1:0] keep_len;
  lane_vec_t        keep;

  always_comb begin
    limit    = CNT_W'(LANES) >> tail_size[1:0];
    active   = (tail_size < TAIL_OFF_MIN) && (loop_cnt <= limit);
    raw_len  = LEN_W'(loop_cnt[4:0]) << tail_size[1:0];
    keep_len = (raw_len > LEN_W'(LANES)) ? LEN_W'(LANES) : raw_len;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[i] = !active || (LEN_W'(i) < keep_len);
  end

  assign out_mask = in_mask & keep;
endmodule

// File: rtl/lpm_beat_stage.sv
module lpm_beat_stage
  import lpm_pkg::*;
(
  input  lane_vec_t  in_mask,
  input  logic [7:0] exec_state,
  output lane_vec_t  out_mask
);
  logic       honour;
  logic [3:0] code;
  logic [1:0] beats_done;
  lane_vec_t  done_lanes;

  always_comb begin
    honour     = (exec_state[3:0] == 4'd0);
    code       = exec_state[7:4];
    beats_done = 2'd0;
    if (honour) begin
      case (code)
        BEAT_ONE:            beats_done = 2'd1;
        BEAT_TWO:            beats_done = 2'd2;
        BEAT_THR, BEAT_THRX: beats_done = 2'd3;
        default:             beats_done = 2'd0;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_done
    localparam int BEAT_IDX = i / BEAT_W;
    assign done_lanes[i] = (2'(BEAT_IDX) < beats_done);
  end

  assign out_mask = in_mask & ~done_lanes;
endmodule

// File: rtl/lpm_elem_pick.sv
module lpm_elem_pick
  import lpm_pkg::*;
(
  input  lane_vec_t  mask,
  input  logic [1:0] op_width,
  output lane_vec_t  elem_en
);
  lane_vec_t byte_sel, half_sel, word_sel;

  for (genvar e = 0; e < LANES; e++) begin : g_elem
    assign byte_sel[e] = mask[e];
    if (e < HALF) begin : g_h
      assign half_sel[e] = mask[2*e];
    end else begin : g_hz
      assign half_sel[e] = 1'b0;
    end
    if (e < QUART) begin : g_w
      assign word_sel[e] = mask[4*e];
    end else begin : g_wz
      assign word_sel[e] = 1'b0;
    end
  end

  always_comb begin
    case (opw_e'(op_width))
      OPW_BYTE: elem_en = byte_sel;
      OPW_HALF: elem_en = half_sel;
      OPW_WORD: elem_en = word_sel;
      default:  elem_en = '0;
    endcase
  end
endmodule

// File: rtl/lane_pred_mask_gen.sv
module lane_pred_mask_gen
  import lpm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      pred_bits,
  input  logic [3:0]       phase_lo,
  input  logic [3:0]       phase_hi,
  input  logic [CNT_W-1:0] loop_cnt,
  input  logic [2:0]       tail_size,
  input  logic [7:0]       exec_state,
  input  logic [1:0]       op_width,
  output logic [15:0]      lane_mask,
  output logic [15:0]      elem_en
);
  lane_vec_t base_m, tail_m, beat_m, elem_m;

  lpm_pred_stage u_pred (
    .pred_bits (pred_bits),
    .phase_lo  (phase_lo),
    .phase_hi  (phase_hi),
    .base_mask (base_m)
  );

  lpm_tail_stage #(.CNT_W(CNT_W)) u_tail (
    .in_mask   (base_m),
    .loop_cnt  (loop_cnt),
    .tail_size (tail_size),
    .out_mask  (tail_m)
  );

  lpm_beat_stage u_beat (
    .in_mask    (tail_m),
    .exec_state (exec_state),
    .out_mask   (beat_m)
  );

  lpm_elem_pick u_pick (
    .mask     (beat_m),
    .op_width (op_width),
    .elem_en  (elem_m)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_mask <= '0;
        elem_en   <= '0;
      end else begin
        lane_mask <= beat_m;
        elem_en   <= elem_m;
      end
    end
  end else begin : g_comb
    assign lane_mask = beat_m;
    assign elem_en   = elem_m;
  end
endmodule

// File: rtl/lane_pred_mask_chk.sv
module lane_pred_mask_chk #(
  parameter int CNT_W   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      pred_bits,
  input logic [3:0]       phase_lo,
  input logic [3:0]       phase_hi,
  input logic [CNT_W-1:0] loop_cnt,
  input logic [2:0]       tail_size,
  input logic [7:0]       exec_state,
  input logic [1:0]       op_width,
  input logic [15:0]      lane_mask,
  input logic [15:0]      elem_en
);
  if (REG_OUT) begin : g_seq
    a_r1_low_open: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_lo == 4'd0 && exec_state[3:0] != 4'd0 && tail_size >= 3'd4)
      |=> (lane_mask[7:0] == 8'hFF));
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_size == 3'd0 && loop_cnt == '0) |=> (lane_mask == 16'h0000));
    a_r5_code_one: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_state == 8'h10) |=> (lane_mask[3:0] == 4'h0));
    a_r6_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_state == 8'h30 && phase_lo == 4'd0 && phase_hi == 4'd0 &&
       tail_size >= 3'd4) |=> (lane_mask == 16'hFFFF));
    a_r7_word_range: assert property (@(posedge clk) disable iff (!rst_n)
      (op_width == 2'd2) |=> (elem_en[15:4] == 12'h000));
    a_r7_byte_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (op_width == 2'd0) |=> (elem_en == lane_mask));
  end else begin : g_comb
    a_r1_low_open: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_lo == 4'd0 && exec_state[3:0] != 4'd0 && tail_size >= 3'd4)
      |-> (lane_mask[7:0] == 8'hFF));
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_size == 3'd0 && loop_cnt == '0) |-> (lane_mask == 16'h0000));
    a_r5_code_one: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_state == 8'h10) |-> (lane_mask[3:0] == 4'h0));
    a_r7_word_range: assert property (@(posedge clk) disable iff (!rst_n)
      (op_width == 2'd2) |-> (elem_en[15:4] == 12'h000));
  end
endmodule

bind lane_pred_mask_gen lane_pred_mask_chk #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pred_bits  (pred_bits),
  .phase_lo   (phase_lo),
  .phase_hi   (phase_hi),
  .loop_cnt   (loop_cnt),
  .tail_size  (tail_size),
  .exec_state (exec_state),
  .op_width   (op_width),
  .lane_mask  (lane_mask),
  .elem_en    (elem_en)
);

// File: tb/lane_pred_mask_gen_tb_top.sv
module lane_pred_mask_gen_tb_top;
  localparam int CNT_W = 32;
  localparam int NV    = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      pred_bits = '0;
  logic [3:0]       phase_lo = '0;
  logic [3:0]       phase_hi = '0;
  logic [CNT_W-1:0] loop_cnt = '0;
  logic [2:0]       tail_size = '0;
  logic [7:0]       exec_state = '0;
  logic [1:0]       op_width = '0;
  logic [15:0]      lane_mask, elem_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_pred_mask_gen #(.CNT_W(CNT_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pred_bits(pred_bits), .phase_lo(phase_lo),
    .phase_hi(phase_hi), .loop_cnt(loop_cnt), .tail_size(tail_size),
    .exec_state(exec_state), .op_width(op_width),
    .lane_mask(lane_mask), .elem_en(elem_en)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] pred;
    logic [3:0]  plo;
    logic [3:0]  phi;
    logic [31:0] cnt;
    logic [2:0]  size;
    logic [7:0]  state;
    logic [1:0]  opw;
    logic [15:0] exp_mask;
    logic [15:0] exp_en;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd1, 16'h1234, 4'h0, 4'h0, 32'd100, 3'd0, 8'h00, 2'd0, 16'hFFFF, 16'hFFFF}, // R1 both halves open
    '{4'd1, 16'h1234, 4'h8, 4'h4, 32'd100, 3'd0, 8'h01, 2'd0, 16'h1234, 16'h1234}, // R1 predicate kept, R4 guard
    '{4'd5, 16'hA5C3, 4'h1, 4'h0, 32'd100, 3'd0, 8'h10, 2'd1, 16'hFFC0, 16'h00F8}, // R5 code 1, R7 halfword
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd5,   3'd0, 8'h00, 2'd0, 16'h001F, 16'h001F}, // R2 byte tail
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd3,   3'd1, 8'h00, 2'd1, 16'h003F, 16'h0007}, // R2 half tail
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd2,   3'd2, 8'h00, 2'd2, 16'h00FF, 16'h0003}, // R2 word tail
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd1,   3'd3, 8'h00, 2'd2, 16'h00FF, 16'h0003}, // R2 size 3
    '{4'd3, 16'h0000, 4'h0, 4'h0, 32'd1,   3'd4, 8'h00, 2'd0, 16'hFFFF, 16'hFFFF}, // R3 size 4 off
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd0,   3'd0, 8'h00, 2'd0, 16'h0000, 16'h0000}, // R2 count 0
    '{4'd2, 16'h0000, 4'h0, 4'h0, 32'd16,  3'd0, 8'h00, 2'd0, 16'hFFFF, 16'hFFFF}, // R2 count 16
    '{4'd3, 16'h0000, 4'h0, 4'h0, 32'd17,  3'd0, 8'h00, 2'd0, 16'hFFFF, 16'hFFFF}, // R3 above window
    '{4'd3, 16'h0000, 4'h0, 4'h0, 32'h80000002, 3'd0, 8'h00, 2'd0, 16'hFFFF, 16'hFFFF}, // R3 high count bit
    '{4'd5, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h20, 2'd2, 16'hFF00, 16'h000C}, // R5 code 2
    '{4'd5, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h40, 2'd2, 16'hF000, 16'h0008}, // R5 code 4
    '{4'd5, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h50, 2'd2, 16'hF000, 16'h0008}, // R5 code 5
    '{4'd6, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h30, 2'd0, 16'hFFFF, 16'hFFFF}, // R6 code 3
    '{4'd6, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h60, 2'd0, 16'hFFFF, 16'hFFFF}, // R6 code 6
    '{4'd4, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h21, 2'd0, 16'hFFFF, 16'hFFFF}, // R4 guard nonzero
    '{4'd5, 16'h0F0F, 4'h2, 4'h3, 32'd3,   3'd2, 8'h10, 2'd0, 16'h0F00, 16'h0F00}, // R5 with R1 and R2 chain
    '{4'd7, 16'h0000, 4'h0, 4'h0, 32'd100, 3'd0, 8'h00, 2'd3, 16'hFFFF, 16'h0000}  // R7 width code 3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pred_bits = v.pred; phase_lo = v.plo; phase_hi = v.phi;
    loop_cnt = v.cnt; tail_size = v.size; exec_state = v.state; op_width = v.opw;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset lane_mask", lane_mask, 16'h0000);
    check("R8 reset elem_en", elem_en, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d lane_mask", VECS[i].req, i), lane_mask, VECS[i].exp_mask);
      check($sformatf("R%0d vec %0d elem_en", VECS[i].req, i), elem_en, VECS[i].exp_en);
    end
    // R8 latency: output holds the previous result until the next edge
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    check("R8 settle", lane_mask, 16'hFFFF);
    drive(VECS[8]);
    #5;
    check("R8 old value before edge", lane_mask, 16'hFFFF);
    @(negedge clk);
    check("R8 new value after edge", lane_mask, 16'h0000);
    // R3 size 2 just above window, R2 size 2 at window edge
    drive('{4'd3, 16'h0, 4'h0, 4'h0, 32'd5, 3'd2, 8'h00, 2'd0, 16'h0, 16'h0});
    @(negedge clk);
    check("R3 size 2 count 5", lane_mask, 16'hFFFF);
    drive('{4'd2, 16'h0, 4'h0, 4'h0, 32'd4, 3'd2, 8'h00, 2'd0, 16'h0, 16'h0});
    @(negedge clk);
    check("R2 size 2 count 4", lane_mask, 16'hFFFF);
    // R8 reset mid-run clears outputs
    rst_n = 1'b0;
    #2;
    check("R8 async reset lane_mask", lane_mask, 16'h0000);
    check("R8 async reset elem_en", elem_en, 16'h0000);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule